// File: doc/BRIEF.md
# Multicast Hash Address Filter

This block sits on the receive side of an Ethernet MAC. It decides, from a frame's 48-bit destination address, whether the frame is kept or dropped. A one-cycle strobe presents the address. Two clock cycles later the block returns a verdict and a flag that marks the destination as a group (multicast) address, which statistics logic can count.

Three kinds of configuration input steer the verdict. The first is the station's own address, split into a 32-bit low word and a 16-bit high word. The second is a 64-bin group hash table, split into two 32-bit words. The third is three mode bits: promiscuous, accept-all-group and hash. The hash bin for a group address comes from a CRC-32 over the six address bytes, computed inside the block in a single cycle. The modes are evaluated in a fixed priority order, with promiscuous first.

Top module: `mhf_addr_filter`

## Requirements
- R1: `out_valid` is high for exactly one cycle, two clock cycles after each cycle in which `dst_valid` is high. While `out_valid` is low, `out_accept` and `out_mcast` are low.
- R2: Address byte k sits at `dst_addr[8k+7:8k]`. `out_mcast` equals bit 0 of byte 0 (`dst_addr[0]`).
- R3: With `promisc_en` set, every address is accepted, whatever the other settings are.
- R4: `station_lo` holds bytes 0..3 with byte 0 in bits [7:0]. `station_hi` holds bytes 4..5 with byte 4 in bits [7:0]. An individual address (bit 0 clear) is accepted only when all 48 bits equal the station address.
- R5: The all-ones broadcast address is accepted under every combination of mode bits and table contents.
- R6: With `all_mcast_en` set, every group address is accepted, whatever the table holds and whatever `hash_en` is.
- R7: With `hash_en` set, a non-broadcast group address is accepted exactly when its table bin is set. The CRC register starts at all ones and runs over bytes 0..5, least significant bit first, with the reflected polynomial 0xEDB88320 and no final inversion. The bin index is register bits [31:26]. Index 0..31 selects `hash_lo[index]` and index 32..63 selects `hash_hi[index-32]`.
- R8: With `hash_en`, `all_mcast_en` and `promisc_en` all clear, a non-broadcast group address is rejected, even when every table bit is set.
- R9: An individual address that differs from the station address is rejected even when the table is all ones and `all_mcast_en` and `hash_en` are set.
- R10: After reset, `out_valid`, `out_accept` and `out_mcast` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dst_valid | input | 1 | Strobe: `dst_addr` holds a destination this cycle |
| dst_addr | input | 48 | Destination address, byte 0 in bits [7:0] |
| station_lo | input | 32 | Station address bytes 0..3 |
| station_hi | input | 16 | Station address bytes 4..5 |
| hash_lo | input | 32 | Hash table bins 0..31 |
| hash_hi | input | 32 | Hash table bins 32..63 |
| promisc_en | input | 1 | Accept every frame |
| all_mcast_en | input | 1 | Accept every group address |
| hash_en | input | 1 | Enable hash table lookup for group addresses |
| out_valid | output | 1 | Verdict valid |
| out_accept | output | 1 | Frame accepted |
| out_mcast | output | 1 | Destination is a group address |

## Verification
The bench builds the block with its default parameters: six address bytes, a six-bit bin index and 32-bit table words. At that size all 64 bins can be reached. The sweep drives one group address per bin and checks it against a table with only that bin set, against a table with only that bin cleared, and with hashing disabled. The same configuration keeps the station address small enough to flip each of its 47 non-group bits one at a time, so every mismatch position of the unicast compare is exercised.

// File: rtl/mhf_pkg.sv
package mhf_pkg;

    typedef struct packed {
        logic promisc;
        logic all_mcast;
        logic hash_en;
    } mode_t;

    // One data bit through a reflected CRC register.
    function automatic logic [31:0] crc_bit(input logic [31:0] c,
                                            input logic        d,
                                            input logic [31:0] poly);
        logic [31:0] n;
        n = c >> 1;
        if (c[0] ^ d) n = n ^ poly;
        return n;
    endfunction

endpackage

// File: rtl/mhf_crc.sv
module mhf_crc #(
    parameter int          ADDR_BYTES = 6,
    parameter int          IDX_W      = 6,
    parameter logic [31:0] POLY       = 32'hEDB88320,
    localparam int         ADDR_W     = ADDR_BYTES * 8
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [IDX_W-1:0]  bin_idx
);
    import mhf_pkg::*;

    logic [31:0] crc_acc;

    always_comb begin
        crc_acc = '1;
        for (int b = 0; b < ADDR_BYTES; b++) begin
            for (int k = 0; k < 8; k++) begin
                crc_acc = crc_bit(crc_acc, addr[b*8 + k], POLY);
            end
        end
        bin_idx = crc_acc[31 -: IDX_W];
    end

endmodule

// File: rtl/mhf_lookup.sv
module mhf_lookup #(
    parameter int  IDX_W = 6,
    localparam int BINS  = 1 << IDX_W
) (
    input  logic [BINS-1:0]  table_bits,
    input  logic [IDX_W-1:0] bin_idx,
    output logic             hit
);
    always_comb begin
        hit = table_bits[bin_idx];
    end
endmodule

// File: rtl/mhf_decide.sv
module mhf_decide #(
    parameter int  ADDR_BYTES = 6,
    localparam int ADDR_W     = ADDR_BYTES * 8
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] station,
    input  mhf_pkg::mode_t    mode,
    input  logic              bin_hit,
    output logic              accept,
    output logic              group
);
    logic bcast;
    logic own;

    always_comb begin
        group  = addr[0];
        bcast  = &addr;
        own    = (addr == station);
        if (mode.promisc)
            accept = 1'b1;
        else if (group)
            accept = bcast | mode.all_mcast | (mode.hash_en & bin_hit);
        else
            accept = own;
    end
endmodule

// File: rtl/mhf_addr_filter.sv
module mhf_addr_filter #(
    parameter int          ADDR_BYTES = 6,
    parameter int          IDX_W      = 6,
    parameter int          REG_W      = 32,
    parameter logic [31:0] POLY       = 32'hEDB88320,
    localparam int         ADDR_W     = ADDR_BYTES * 8,
    localparam int         HI_W       = ADDR_W - REG_W,
    localparam int         BINS       = 1 << IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dst_valid,
    input  logic [ADDR_W-1:0] dst_addr,
    input  logic [REG_W-1:0]  station_lo,
    input  logic [HI_W-1:0]   station_hi,
    input  logic [REG_W-1:0]  hash_lo,
    input  logic [REG_W-1:0]  hash_hi,
    input  logic              promisc_en,
    input  logic              all_mcast_en,
    input  logic              hash_en,
    output logic              out_valid,
    output logic              out_accept,
    output logic              out_mcast
);
    import mhf_pkg::*;

    typedef struct packed {
        logic              v;
        logic [ADDR_W-1:0] addr;
        logic [IDX_W-1:0]  idx;
    } cap_t;

    typedef struct packed {
        logic v;
        logic accept;
        logic mcast;
    } res_t;

    typedef struct packed {
        cap_t cap;
        res_t res;
    } state_t;

    state_t st_d, st_q;

    logic [IDX_W-1:0] idx_w;
    logic             hit_w;
    logic             acc_w;
    logic             grp_w;
    mode_t            mode_w;

    assign mode_w = '{promisc: promisc_en, all_mcast: all_mcast_en, hash_en: hash_en};

    mhf_crc #(.ADDR_BYTES(ADDR_BYTES), .IDX_W(IDX_W), .POLY(POLY)) u_crc (
        .addr    (dst_addr),
        .bin_idx (idx_w)
    );

    mhf_lookup #(.IDX_W(IDX_W)) u_lookup (
        .table_bits ({hash_hi, hash_lo}),
        .bin_idx    (st_q.cap.idx),
        .hit        (hit_w)
    );

    mhf_decide #(.ADDR_BYTES(ADDR_BYTES)) u_decide (
        .addr    (st_q.cap.addr),
        .station ({station_hi, station_lo}),
        .mode    (mode_w),
        .bin_hit (hit_w),
        .accept  (acc_w),
        .group   (grp_w)
    );

    always_comb begin
        st_d = st_q;
        st_d.cap.v = dst_valid;
        if (dst_valid) begin
            st_d.cap.addr = dst_addr;
            st_d.cap.idx  = idx_w;
        end
        st_d.res.v      = st_q.cap.v;
        st_d.res.accept = st_q.cap.v & acc_w;
        st_d.res.mcast  = st_q.cap.v & grp_w;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid  = st_q.res.v;
    assign out_accept = st_q.res.accept;
    assign out_mcast  = st_q.res.mcast;

    assert_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == $past(dst_valid, 2));

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (!out_accept && !out_mcast));

    assert_group_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_mcast == $past(dst_addr[0], 2)));

    assert_promisc_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(promisc_en)) |-> out_accept);

    assert_unicast_exact_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !$past(promisc_en) && !$past(dst_addr[0], 2)) |->
        (out_accept == ($past(dst_addr, 2) == {$past(station_hi), $past(station_lo)})));

    assert_broadcast_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && ($past(dst_addr, 2) == '1)) |-> out_accept);

    assert_group_blocked_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !$past(promisc_en) && !$past(all_mcast_en) && !$past(hash_en)
         && $past(dst_addr[0], 2) && ($past(dst_addr, 2) != '1)) |-> !out_accept);

endmodule

// File: tb/test_mhf_addr_filter.sv
module test_mhf_addr_filter;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dst_valid = 1'b0;
    logic [47:0] dst_addr = '0;
    logic [31:0] station_lo = '0;
    logic [15:0] station_hi = '0;
    logic [31:0] hash_lo = '0;
    logic [31:0] hash_hi = '0;
    logic        promisc_en = 1'b0;
    logic        all_mcast_en = 1'b0;
    logic        hash_en = 1'b0;
    logic        out_valid, out_accept, out_mcast;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    mhf_addr_filter i_mhf_addr_filter (
        .clk, .rst_n, .dst_valid, .dst_addr, .station_lo, .station_hi,
        .hash_lo, .hash_hi, .promisc_en, .all_mcast_en, .hash_en,
        .out_valid, .out_accept, .out_mcast
    );

    localparam logic [47:0] STATION = 48'h6655_4433_2210;

    function automatic logic [5:0] bin_of(input logic [47:0] a);
        logic [31:0] c;
        c = 32'hFFFF_FFFF;
        for (int i = 0; i < 48; i++) begin
            if (c[0] ^ a[i]) c = (c >> 1) ^ 32'hEDB88320;
            else             c = c >> 1;
        end
        return c[31:26];
    endfunction

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic set_table(input logic [63:0] t);
        hash_lo = t[31:0];
        hash_hi = t[63:32];
    endtask

    task automatic set_modes(input logic p, input logic a, input logic h);
        promisc_en = p;
        all_mcast_en = a;
        hash_en = h;
    endtask

    // Strobe one address and check the verdict two cycles later.
    task automatic send(input logic [47:0] a, input logic exp_acc, input string req);
        @(negedge clk);
        dst_valid = 1'b1;
        dst_addr  = a;
        @(posedge clk); #1;
        check("R1 early", out_valid, 1'b0);
        @(negedge clk);
        dst_valid = 1'b0;
        @(posedge clk); #1;
        check("R1 valid", out_valid, 1'b1);
        check("R2 group flag", out_mcast, a[0]);
        check(req, out_accept, exp_acc);
        @(posedge clk); #1;
        check("R1 single", out_valid, 1'b0);
        check("R1 quiet", out_accept | out_mcast, 1'b0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        station_lo = STATION[31:0];
        station_hi = STATION[47:32];
        repeat (3) @(posedge clk);
        #1;
        check("R10 valid", out_valid, 1'b0);
        check("R10 accept", out_accept, 1'b0);
        check("R10 mcast", out_mcast, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;

        // R4: exact unicast match
        set_modes(0, 0, 0);
        set_table('0);
        send(STATION, 1'b1, "R4 own address");

        // R9 / R4: single-bit mismatches, permissive group settings
        set_modes(0, 1, 1);
        set_table('1);
        for (int b = 1; b < 48; b++) begin
            send(STATION ^ (48'h1 << b), 1'b0, "R9 unicast mismatch");
        end

        // R5: broadcast in every mode combination with an empty table
        set_table('0);
        for (int m = 0; m < 8; m++) begin
            set_modes(m[2], m[1], m[0]);
            send('1, 1'b1, "R5 broadcast");
        end

        // R8: group address, no group mode, full table
        set_modes(0, 0, 0);
        set_table('1);
        send(48'h0000_0000_5E01, 1'b0, "R8 group blocked");

        // R6: accept-all-group, empty table, hash on and off
        set_table('0);
        set_modes(0, 1, 0);
        send(48'h0000_0000_5E01, 1'b1, "R6 all group");
        set_modes(0, 1, 1);
        send(48'hABCD_EF12_3403, 1'b1, "R6 all group hash on");

        // R3: promiscuous over unicast mismatch and empty-table group
        set_modes(1, 0, 0);
        send(48'h1234_5678_9A00, 1'b1, "R3 promisc unicast");
        set_modes(1, 0, 1);
        send(48'h1234_5678_9A01, 1'b1, "R3 promisc group");

        // R7 / R8: one address per bin
        for (int k = 0; k < 64; k++) begin
            logic [47:0] a;
            logic [5:0]  ix;
            logic [63:0] one;
            a   = {8'h5A ^ 8'(k), 8'h3C, 8'(k * 7), 8'hC3, 8'(k), 8'(k << 1) | 8'h01};
            ix  = bin_of(a);
            one = 64'h1 << ix;
            set_modes(0, 0, 1);
            set_table(one);
            send(a, (a != '1), "R7 bin set");
            set_table(~one);
            send(a, 1'b0, "R7 bin clear");
            set_modes(0, 0, 0);
            set_table(one);
            send(a, 1'b0, "R8 hash off");
        end

        // R7: sweep bins directly so each of the 64 bins is hit
        for (int t = 0; t < 64; t++) begin
            for (int s = 0; s < 4096; s++) begin
                logic [47:0] a;
                a = {16'h0100, 16'(s), 8'(t), 8'h01};
                if (bin_of(a) == 6'(t)) begin
                    set_modes(0, 0, 1);
                    set_table(64'h1 << t);
                    send(a, 1'b1, "R7 bin sweep");
                    break;
                end
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule